// File: doc/BRIEF.md
# Modulator Bitstream Output Interleaver

This block serves the raw-modulator output mode of a stereo sigma-delta converter. The mode bypasses decimation. While the mode is enabled, the block receives one multibit modulator word per channel at the modulator rate and places both words on a single narrow data bus. It also produces a companion clock on a pin shared with the normal serial data output. The level of that clock tells a receiver which channel the bus carries: the left word goes with the low level and the right word with the high level.

The companion clock comes from dividing the master clock by a parameter (by default 4, giving 128 times the sample rate from a 512 times master clock). A new left/right pair is taken once per companion-clock period, so both halves of one period always come from the same modulator sample. The bus moves one master cycle after each companion-clock edge, which leaves the word steady across the edge where a receiver samples it. Turning the mode on or off takes effect only at a period boundary, so the shared pin never shows a shortened clock phase.

Top module: `modstream_interleaver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mod_d` is 0, `mod_d_oe` is 0 and `shared_out` follows `ser_data_in`.
- R2: A phase counter starts at 0 at reset and advances by one, modulo DIV, on every master edge. While the mode is active, `shared_out` is low in phases 0 to DIV/2-1 and high in phases DIV/2 to DIV-1.
- R3: `mode_en` is sampled only at the edge that moves the phase from DIV-1 to 0. A change of `mode_en` at any other phase has no effect until that edge.
- R4: While the mode is inactive, `mod_d` is 0, `mod_d_oe` is 0 and `shared_out` equals `ser_data_in`.
- R5: `left_word` and `right_word` are sampled together, only at the edge that moves the phase from DIV-1 to 0. Their values at every other edge have no effect on the bus.
- R6: While active, the bus carries the captured left word in phases 1 to DIV/2. This covers the rising edge of `shared_out`.
- R7: While active, the bus carries the captured right word from phase DIV/2+1 until the next phase 0 ends. In the first period after activation, phase 0 shows 0.
- R8: `mod_d_oe` is 1 exactly while the mode is active. It rises and falls together with the switch of `shared_out` at a period boundary, and at deactivation the bus returns to 0 at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock (DIV times the companion clock rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Raw-modulator output mode request |
| left_word | input | DATA_W | Left modulator word |
| right_word | input | DATA_W | Right modulator word |
| ser_data_in | input | 1 | Normal serial data routed to the shared pin when inactive |
| mod_d | output | DATA_W | Interleaved modulator data bus |
| mod_d_oe | output | 1 | Output enable for the data bus |
| shared_out | output | 1 | Companion clock when active, otherwise serial data |

## Verification
The hardest case to reach is a mode request that arrives at each of the DIV phases, together with the first and last period around every switch. To get there, the bench toggles `mode_en` with a 37-cycle pattern, which is coprime to the divider, so requests land on every phase. It also changes the data inputs at every non-boundary edge to garbage values, so any capture at the wrong phase shows up on the bus. Across roughly a thousand periods the boundary-captured pairs run through all 256 left/right combinations.

// File: rtl/modint_pkg.sv
package modint_pkg;

  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_LEFT  = 2'd1,
    SLOT_RIGHT = 2'd2,
    SLOT_CLEAR = 2'd3
  } slot_e;

  // Phase that follows ph in a divider of length div.
  function automatic int unsigned phase_after(input int unsigned ph, input int unsigned div);
    return (ph + 1 >= div) ? 0 : ph + 1;
  endfunction

  // Level of the companion clock in a given phase.
  function automatic logic clk_level(input int unsigned ph, input int unsigned div);
    return ph >= div / 2;
  endfunction

  // Which word the bus loads when entering phase ph_nx.
  function automatic slot_e slot_for(input logic act_nx, input int unsigned ph_nx,
                                     input int unsigned div);
    if (!act_nx)                 return SLOT_CLEAR;
    else if (ph_nx == 1)         return SLOT_LEFT;
    else if (ph_nx == div/2 + 1) return SLOT_RIGHT;
    else                         return SLOT_HOLD;
  endfunction

endpackage

// File: rtl/modint_clkdiv.sv
module modint_clkdiv
  import modint_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mme,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             period_end,
  output logic             act_q,
  output logic             act_nx,
  output logic             modclk_q
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DIV / 2);

  assign cnt_nx     = CNT_W'(phase_after(32'(cnt_q), DIV));
  assign period_end = (cnt_q == LAST);
  assign act_nx     = period_end ? mme : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_q    <= 1'b0;
      modclk_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      act_q    <= act_nx;
      modclk_q <= clk_level(32'(cnt_nx), DIV);
    end
  end

  assert_switch_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> (cnt_q == '0));

  assert_modclk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modclk_q) |-> (cnt_q == HALF_C));

  assert_modclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modclk_q) |-> (cnt_q == '0));

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/modint_capture.sv
module modint_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic [DATA_W-1:0] cap_l,
  output logic [DATA_W-1:0] cap_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_l <= '0;
      cap_r <= '0;
    end else if (cap_en) begin
      cap_l <= left_in;
      cap_r <= right_in;
    end
  end

  assert_pair_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(cap_l) && $stable(cap_r)));

endmodule

// File: rtl/modint_outmux.sv
module modint_outmux
  import modint_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int DIV    = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] cap_l,
  input  logic [DATA_W-1:0] cap_r,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              act_q,
  input  logic              modclk_q,
  input  logic              ser_in,
  output logic [DATA_W-1:0] d_q,
  output logic              oe_q,
  output logic              pin
);
  localparam logic [CNT_W-1:0] PH_LEFT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] PH_RIGHT = CNT_W'(DIV / 2 + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= '0;
      oe_q <= 1'b0;
    end else begin
      unique case (slot)
        SLOT_CLEAR: begin d_q <= '0;    oe_q <= 1'b0; end
        SLOT_LEFT:  begin d_q <= cap_l; oe_q <= 1'b1; end
        SLOT_RIGHT: begin d_q <= cap_r; oe_q <= 1'b1; end
        default:    begin               oe_q <= 1'b1; end
      endcase
    end
  end

  assign pin = act_q ? modclk_q : ser_in;

  assert_bus_moves_after_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(d_q) |-> (cnt_q == PH_LEFT || cnt_q == PH_RIGHT || cnt_q == '0));

  assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (d_q == '0));

  assert_oe_tracks_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q == act_q);

endmodule

// File: rtl/modstream_interleaver.sv
module modstream_interleaver
  import modint_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int DIV    = 4
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic [DATA_W-1:0] left_word,
  input  logic [DATA_W-1:0] right_word,
  input  logic              ser_data_in,
  output logic [DATA_W-1:0] mod_d,
  output logic              mod_d_oe,
  output logic              shared_out
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              period_end, act_q, act_nx, modclk_q;
  logic [DATA_W-1:0] cap_l, cap_r;
  slot_e             slot;

  modint_clkdiv #(.DIV(DIV), .CNT_W(CNT_W)) u_div (
    .clk(mclk), .rst_n(rst_n), .mme(mode_en),
    .cnt_q(cnt_q), .cnt_nx(cnt_nx), .period_end(period_end),
    .act_q(act_q), .act_nx(act_nx), .modclk_q(modclk_q)
  );

  modint_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(mclk), .rst_n(rst_n), .cap_en(period_end),
    .left_in(left_word), .right_in(right_word),
    .cap_l(cap_l), .cap_r(cap_r)
  );

  assign slot = slot_for(act_nx, 32'(cnt_nx), DIV);

  modint_outmux #(.DATA_W(DATA_W), .DIV(DIV), .CNT_W(CNT_W)) u_mux (
    .clk(mclk), .rst_n(rst_n), .slot(slot),
    .cap_l(cap_l), .cap_r(cap_r), .cnt_q(cnt_q),
    .act_q(act_q), .modclk_q(modclk_q), .ser_in(ser_data_in),
    .d_q(mod_d), .oe_q(mod_d_oe), .pin(shared_out)
  );

endmodule

// File: tb/modstream_interleaver_tb.sv
module modstream_interleaver_tb;
  localparam int DATA_W = 4;
  localparam int DIV    = 4;
  localparam int HALF   = DIV / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_en = 1'b0;
  logic [DATA_W-1:0] left_word = '0, right_word = '0;
  logic              ser_data_in = 1'b0;
  logic [DATA_W-1:0] mod_d;
  logic              mod_d_oe, shared_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modstream_interleaver #(.DATA_W(DATA_W), .DIV(DIV)) u_dut (
    .mclk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .left_word(left_word), .right_word(right_word), .ser_data_in(ser_data_in),
    .mod_d(mod_d), .mod_d_oe(mod_d_oe), .shared_out(shared_out)
  );

  // Reference state, derived from the requirements
  int                ph;
  bit                ract;
  logic [DATA_W-1:0] rl, rr, rbus;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; ract = 0; rl = '0; rr = '0; rbus = '0;
    end else begin
      if (ph == DIV - 1) begin        // R3, R5: boundary sampling
        ract = mode_en;
        rl = left_word;
        rr = right_word;
      end
      ph = (ph + 1) % DIV;
      if (!ract)               rbus = '0;   // R4, R8
      else if (ph == 1)        rbus = rl;   // R6
      else if (ph == HALF + 1) rbus = rr;   // R7
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (phase %0d)", req, got, exp, ph);
    end
  endtask

  task automatic check_cycle();
    if (!ract) begin
      chk("R4 shared pin", int'(shared_out), int'(ser_data_in));
      chk("R4 bus", int'(mod_d), 0);
      chk("R4 R8 oe", int'(mod_d_oe), 0);
    end else begin
      chk("R2 companion clock", int'(shared_out), (ph >= HALF) ? 1 : 0);
      chk("R8 oe", int'(mod_d_oe), 1);
      if (ph >= 1 && ph <= HALF) chk("R5 R6 left slot", int'(mod_d), int'(rbus));
      else                       chk("R5 R7 right slot", int'(mod_d), int'(rbus));
    end
    if (ract != mode_en) chk("R3 pending switch oe", int'(mod_d_oe), int'(ract));
  endtask

  initial begin
    int pair;
    pair = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset bus", int'(mod_d), 0);
    chk("R1 reset oe", int'(mod_d_oe), 0);
    ser_data_in = 1'b1;
    #1 chk("R1 reset shared pin", int'(shared_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset bus", int'(mod_d), 0);
    chk("R1 post-reset oe", int'(mod_d_oe), 0);
    chk("R1 post-reset pin", int'(shared_out), int'(ser_data_in));
    for (int cyc = 0; cyc < 4400; cyc++) begin
      check_cycle();
      mode_en     = ((cyc % 37) >= 9);
      ser_data_in = cyc[0] ^ cyc[3];
      if (ph == DIV - 1) begin
        left_word  = DATA_W'(pair);
        right_word = DATA_W'(pair >> DATA_W);
        pair = (pair + 1) % (1 << (2 * DATA_W));
      end else begin
        left_word  = DATA_W'(cyc * 7 + 3);     // garbage off the boundary (R5)
        right_word = DATA_W'(cyc * 5 + 11);
      end
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule